// File: doc/BRIEF.md
# Pulse-Width Serial Time Code Generator with Programmable Delay

The block produces an unmodulated, level-shifted serial time code on a single output pin. Every second it sends one frame of 100 pulse-width-coded symbols, one symbol per 10 ms slot. A short high pulse is a zero, a medium pulse is a one and a long pulse is a position marker. Each frame carries the time of day and the day of year as BCD digits, a two-digit year, a small control block with leap-second, daylight-saving and quality flags protected by a parity bit, and the second of the day as a plain binary count.

The frame is started by a one-pulse-per-second reference. A programmable delay, counted in 10 µs ticks and sampled when the reference rises, shifts the whole frame later than the reference. The shift models a clock that has been pushed off true time. After one reference pulse the generator free-runs, one frame per 100 symbol slots. A later reference edge realigns it. The time registers are loaded from the ports and advance by one second per frame. The advance covers leap seconds, day-of-year rollover in normal and leap years, and the wrap of the year count.

Top module: `irig_dcls_gen`

## Requirements
- R1: After reset `code_o` stays low until the first frame starts, that is, until a reference rising edge has been seen and its delay has run out. A load alone does not start output.
- R2: A symbol slot lasts TPB ticks of TICK_DIV clocks. The high time is TPB/5 ticks for a zero, TPB/2 ticks for a one and 4*TPB/5 ticks for a marker. A frame has 100 slots.
- R3: Slots 0, 9, 19, 29, …, 99 are markers. Slot 99 of one frame and slot 0 of the next therefore form the two adjacent markers that identify a frame start.
- R4: The rising edge of slot 0 appears 1 + `offset_i`*TICK_DIV clocks after the clock edge that first samples `pps_i` high after low.
- R5: Time fields are BCD with the LSB first: seconds units in 1-4 and tens in 6-8; minutes units in 10-13 and tens in 15-17; hours units in 20-23 and tens in 25-26; day units in 30-33, tens in 35-38 and hundreds in 40-41; year units in 50-53 and tens in 55-58.
- R6: Slot 60 carries `leap_i`, slot 61 `dst_i`, slots 62-65 `quality_i` (LSB first). Slot 66 is a parity bit that makes the number of ones in slots 1-66 even.
- R7: The second of the day (sec + 60*min + 3600*hour) is sent LSB first: bits 0-8 in slots 80-88 and bits 9-16 in slots 90-97.
- R8: `offset_i` is sampled only on the reference rising edge. Changing it afterwards does not move the pending frame start.
- R9: A load sets the time sent in the next frame. Each frame start sends the current time and then advances it by one second. Without further reference edges, frames repeat every 100 slots.
- R10: With `leap_i` set, 23:59:59 advances to 23:59:60 and then to 00:00:00. Day 365 rolls to day 1, or to day 366 when the year is divisible by 4; day 366 rolls to day 1. The year increments at the day rollover and wraps from 99 to 0.
- R11: Every slot that is not a marker and is not assigned a field is sent as a zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pps_i | input | 1 | One-pulse-per-second reference, synchronous to clk_i |
| offset_i | input | OFS_W | Frame delay in 10 µs ticks |
| load_i | input | 1 | Load start time (one-cycle pulse) |
| ld_sec_i | input | 6 | Start seconds, 0-60 |
| ld_min_i | input | 6 | Start minutes, 0-59 |
| ld_hour_i | input | 5 | Start hours, 0-23 |
| ld_doy_i | input | 9 | Start day of year, 1-366 |
| ld_year_i | input | 7 | Start year, 0-99 |
| leap_i | input | 1 | Leap second scheduled at end of day |
| dst_i | input | 1 | Daylight-saving flag |
| quality_i | input | 4 | Time quality code |
| code_o | output | 1 | Serial time code |

## Verification
The bench measures the start latency for several delay values, including a delay changed just after the reference edge. A design that sampled the delay late, or counted ticks from a free-running prescaler, would start at the wrong cycle. It decodes whole frames across the midnight cases: leap second, day 365 in a normal and in a leap year, day 366, and year 99. A design with a wrong rollover would send a skipped or repeated time, a day 366 in a normal year, or a year of 100. It also checks every pulse width, the 100-slot free-run period and the parity slot. A bit-order or slot-offset mistake would show up as a corrupt field or a misplaced marker.

// File: rtl/irig_pkg.sv
package irig_pkg;

  localparam int unsigned SLOTS = 100;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [8:0] doy;
    logic [6:0] year;
  } tod_t;

  function automatic logic [7:0] bcd2(input logic [6:0] v);
    logic [6:0] t, u;
    t = v / 7'd10;
    u = v % 7'd10;
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic [9:0] bcd3(input logic [8:0] v);
    logic [8:0] h, r, t, u;
    h = v / 9'd100;
    r = v % 9'd100;
    t = r / 9'd10;
    u = r % 9'd10;
    return {h[1:0], t[3:0], u[3:0]};
  endfunction

endpackage

// File: rtl/irig_ref_align.sv
module irig_ref_align #(
  parameter int unsigned TICK_DIV = 1000,
  parameter int unsigned OFS_W    = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pps_i,
  input  logic [OFS_W-1:0] offset_i,
  output logic             tick_o,
  output logic             start_o,
  output logic             rise_o,
  output logic [OFS_W-1:0] dly_o
);
  localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(TICK_DIV - 1);

  logic             pps_q;
  logic             armed_q;
  logic [PRE_W-1:0] pre_q;
  logic [OFS_W-1:0] dly_q;

  assign rise_o  = pps_i & ~pps_q;
  assign tick_o  = (pre_q == PRE_MAX);
  assign start_o = armed_q && (dly_q == '0);
  assign dly_o   = dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pps_q   <= 1'b0;
      armed_q <= 1'b0;
      pre_q   <= '0;
      dly_q   <= '0;
    end else begin
      pps_q <= pps_i;
      if (rise_o) begin
        // prescaler restarts so the delay is counted from the reference edge
        armed_q <= 1'b1;
        dly_q   <= offset_i;
        pre_q   <= '0;
      end else begin
        if (start_o) armed_q <= 1'b0;
        if (start_o || tick_o) pre_q <= '0;
        else                   pre_q <= pre_q + 1'b1;
        if (tick_o && dly_q != '0) dly_q <= dly_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/irig_time_keeper.sv
module irig_time_keeper
  import irig_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  tod_t load_tod_i,
  input  logic leap_i,
  input  logic step_i,
  output tod_t tod_o
);
  tod_t tod_q, tod_n;
  logic leap_now, sec_roll, min_roll, hour_roll, day_roll;
  logic [8:0] last_day;

  assign tod_o     = tod_q;
  assign leap_now  = leap_i && tod_q.hour == 5'd23 && tod_q.min == 6'd59;
  assign sec_roll  = (tod_q.sec == 6'd60) || (tod_q.sec == 6'd59 && !leap_now);
  assign min_roll  = sec_roll && tod_q.min == 6'd59;
  assign hour_roll = min_roll && tod_q.hour == 5'd23;
  assign last_day  = (tod_q.year[1:0] == 2'b00) ? 9'd366 : 9'd365;
  assign day_roll  = hour_roll && tod_q.doy >= last_day;

  always_comb begin
    tod_n = tod_q;
    tod_n.sec = sec_roll ? 6'd0 : tod_q.sec + 6'd1;
    if (sec_roll)  tod_n.min  = min_roll  ? 6'd0 : tod_q.min + 6'd1;
    if (min_roll)  tod_n.hour = hour_roll ? 5'd0 : tod_q.hour + 5'd1;
    if (hour_roll) tod_n.doy  = day_roll  ? 9'd1 : tod_q.doy + 9'd1;
    if (day_roll)  tod_n.year = (tod_q.year == 7'd99) ? 7'd0 : tod_q.year + 7'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tod_q      <= '0;
      tod_q.doy  <= 9'd1;
    end else if (load_i) begin
      tod_q <= load_tod_i;
    end else if (step_i) begin
      tod_q <= tod_n;
    end
  end
endmodule

// File: rtl/irig_frame_pack.sv
module irig_frame_pack
  import irig_pkg::*;
(
  input  tod_t        tod_i,
  input  logic        leap_i,
  input  logic        dst_i,
  input  logic [3:0]  quality_i,
  output logic [SLOTS-1:0] data_o
);
  logic [7:0]  sec_b, min_b, hour_b, year_b;
  logic [9:0]  doy_b;
  logic [16:0] sbs;

  assign sec_b  = bcd2({1'b0, tod_i.sec});
  assign min_b  = bcd2({1'b0, tod_i.min});
  assign hour_b = bcd2({2'b00, tod_i.hour});
  assign year_b = bcd2(tod_i.year);
  assign doy_b  = bcd3(tod_i.doy);
  assign sbs    = 17'(tod_i.sec) + 17'(tod_i.min) * 17'd60 + 17'(tod_i.hour) * 17'd3600;

  always_comb begin
    data_o        = '0;
    data_o[4:1]   = sec_b[3:0];
    data_o[8:6]   = sec_b[6:4];
    data_o[13:10] = min_b[3:0];
    data_o[17:15] = min_b[6:4];
    data_o[23:20] = hour_b[3:0];
    data_o[26:25] = hour_b[5:4];
    data_o[33:30] = doy_b[3:0];
    data_o[38:35] = doy_b[7:4];
    data_o[41:40] = doy_b[9:8];
    data_o[53:50] = year_b[3:0];
    data_o[58:55] = year_b[7:4];
    data_o[60]    = leap_i;
    data_o[61]    = dst_i;
    data_o[65:62] = quality_i;
    data_o[66]    = ^data_o[65:1];
    data_o[88:80] = sbs[8:0];
    data_o[97:90] = sbs[16:9];
  end
endmodule

// File: rtl/irig_bit_shaper.sv
module irig_bit_shaper
  import irig_pkg::*;
#(
  parameter int unsigned TPB = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [SLOTS-1:0] data_i,
  output logic             frame_go_o,
  output logic             active_o,
  output logic [6:0]       slot_o,
  output logic             code_o
);
  localparam int unsigned TC_W = $clog2(TPB);
  localparam logic [TC_W-1:0] T_LAST = TC_W'(TPB - 1);
  localparam logic [TC_W-1:0] W_ZERO = TC_W'(TPB / 5);
  localparam logic [TC_W-1:0] W_ONE  = TC_W'(TPB / 2);
  localparam logic [TC_W-1:0] W_MARK = TC_W'((TPB * 4) / 5);

  logic             active_q;
  logic [6:0]       slot_q;
  logic [TC_W-1:0]  tcnt_q;
  logic [SLOTS-1:0] data_q;
  logic             wrap, is_mark;
  logic [TC_W-1:0]  width;

  assign wrap       = active_q && tick_i && tcnt_q == T_LAST && slot_q == 7'(SLOTS - 1);
  assign frame_go_o = start_i | wrap;
  assign is_mark    = (slot_q == 7'd0) || (slot_q % 7'd10 == 7'd9);
  assign width      = is_mark ? W_MARK : (data_q[slot_q] ? W_ONE : W_ZERO);
  assign code_o     = active_q && (tcnt_q < width);
  assign active_o   = active_q;
  assign slot_o     = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      tcnt_q   <= '0;
      data_q   <= '0;
    end else if (frame_go_o) begin
      active_q <= 1'b1;
      slot_q   <= '0;
      tcnt_q   <= '0;
      data_q   <= data_i;
    end else if (active_q && tick_i) begin
      if (tcnt_q == T_LAST) begin
        tcnt_q <= '0;
        slot_q <= slot_q + 7'd1;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irig_dcls_gen.sv
module irig_dcls_gen
  import irig_pkg::*;
#(
  parameter int unsigned TICK_DIV = 1000,
  parameter int unsigned TPB      = 1000,
  parameter int unsigned OFS_W    = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pps_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic             load_i,
  input  logic [5:0]       ld_sec_i,
  input  logic [5:0]       ld_min_i,
  input  logic [4:0]       ld_hour_i,
  input  logic [8:0]       ld_doy_i,
  input  logic [6:0]       ld_year_i,
  input  logic             leap_i,
  input  logic             dst_i,
  input  logic [3:0]       quality_i,
  output logic             code_o
);
  logic             tick, start, rise, frame_go, active;
  logic [OFS_W-1:0] dly;
  logic [6:0]       slot;
  tod_t             tod, load_tod;
  logic [SLOTS-1:0] frame_data;

  assign load_tod = '{sec: ld_sec_i, min: ld_min_i, hour: ld_hour_i,
                      doy: ld_doy_i, year: ld_year_i};

  irig_ref_align #(.TICK_DIV(TICK_DIV), .OFS_W(OFS_W)) u_align (
    .clk_i, .rst_ni, .pps_i, .offset_i,
    .tick_o(tick), .start_o(start), .rise_o(rise), .dly_o(dly)
  );

  irig_time_keeper u_time (
    .clk_i, .rst_ni, .load_i, .load_tod_i(load_tod), .leap_i,
    .step_i(frame_go), .tod_o(tod)
  );

  irig_frame_pack u_pack (
    .tod_i(tod), .leap_i, .dst_i, .quality_i, .data_o(frame_data)
  );

  irig_bit_shaper #(.TPB(TPB)) u_shape (
    .clk_i, .rst_ni, .tick_i(tick), .start_i(start), .data_i(frame_data),
    .frame_go_o(frame_go), .active_o(active), .slot_o(slot), .code_o
  );
endmodule

// File: rtl/irig_dcls_gen_chk.sv
module irig_dcls_gen_chk
  import irig_pkg::*;
#(
  parameter int unsigned OFS_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             code_o,
  input logic             active,
  input logic [6:0]       slot,
  input logic             rise,
  input logic [OFS_W-1:0] dly,
  input logic             frame_go,
  input logic             load_i,
  input tod_t             tod
);
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !code_o);  // R1

  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> slot < 7'(SLOTS));  // R3

  AST_DLY_ONLY_AT_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> dly <= $past(dly));  // R8

  AST_TOD_STEP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_go || load_i) |=> $stable(tod));  // R9

  AST_TOD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tod.sec <= 6'd60 && tod.min <= 6'd59 && tod.hour <= 5'd23 &&
    tod.doy >= 9'd1 && tod.doy <= 9'd366 && tod.year <= 7'd99);  // R10
endmodule

bind irig_dcls_gen irig_dcls_gen_chk #(.OFS_W(OFS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .code_o(code_o), .active(active),
  .slot(slot), .rise(rise), .dly(dly), .frame_go(frame_go),
  .load_i(load_i), .tod(tod)
);

// File: tb/irig_dcls_gen_bench.sv
module irig_dcls_gen_bench;
  localparam int TICK_DIV = 2;
  localparam int TPB      = 10;
  localparam int OFS_W    = 10;
  localparam int FRAME_C  = 100 * TPB * TICK_DIV;
  localparam int MAXF     = 4;

  logic clk = 1'b0, rst_n = 1'b0, pps = 1'b0, load = 1'b0;
  logic [OFS_W-1:0] offset = '0;
  logic [5:0] ld_sec = '0, ld_min = '0;
  logic [4:0] ld_hour = '0;
  logic [8:0] ld_doy = 9'd1;
  logic [6:0] ld_year = '0;
  logic leap = 1'b0, dst = 1'b0;
  logic [3:0] qual = '0;
  logic code;

  int errors = 0, checks = 0;
  bit done = 0;

  irig_dcls_gen #(.TICK_DIV(TICK_DIV), .TPB(TPB), .OFS_W(OFS_W)) u_irig_dcls_gen (
    .clk_i(clk), .rst_ni(rst_n), .pps_i(pps), .offset_i(offset), .load_i(load),
    .ld_sec_i(ld_sec), .ld_min_i(ld_min), .ld_hour_i(ld_hour), .ld_doy_i(ld_doy),
    .ld_year_i(ld_year), .leap_i(leap), .dst_i(dst), .quality_i(qual), .code_o(code)
  );

  always #5 clk = ~clk;

  // symbol monitor: 0 zero, 1 one, 2 marker
  bit mon_clr = 1;
  int cyc = 0, run = 0, rise_c = 0, frise = 0, pos = 0, fcnt = 0, width_err = 0;
  bit prev_mark = 1;
  int fb [0:99];
  int frames [0:MAXF-1][0:99];
  int frame_rise [0:MAXF-1];
  int exp_sym [0:99];

  always @(negedge clk) begin
    if (mon_clr) begin
      run = 0; prev_mark = 1; pos = 0; fcnt = 0; width_err = 0;
    end else if (code) begin
      if (run == 0) rise_c = cyc;
      run++;
    end else if (run > 0) begin
      int typ;
      typ = (run <= 7) ? 0 : ((run <= 13) ? 1 : 2);
      if (!(run == 4 || run == 10 || run == 16)) width_err++;
      if (typ == 2 && prev_mark) pos = 0;
      else if (pos < 100) pos++;
      if (pos == 0) frise = rise_c;
      if (pos < 100) fb[pos] = typ;
      if (pos == 99 && fcnt < MAXF) begin
        for (int k = 0; k < 100; k++) frames[fcnt][k] = fb[k];
        frame_rise[fcnt] = frise;
        fcnt++;
      end
      prev_mark = (typ == 2);
      run = 0;
    end
    cyc++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic do_reset();
    mon_clr = 1; rst_n = 0; pps = 0; load = 0; offset = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    mon_clr = 0;
  endtask

  task automatic do_load(input int s, m, h, d, y);
    ld_sec = 6'(s); ld_min = 6'(m); ld_hour = 5'(h); ld_doy = 9'(d); ld_year = 7'(y);
    load = 1; @(negedge clk); load = 0;
  endtask

  task automatic pulse_pps();
    pps = 1; repeat (5) @(negedge clk); pps = 0;
  endtask

  function automatic string ptag(input int p);
    if (p == 0 || p % 10 == 9) return "R3";
    if (p >= 60 && p <= 66) return "R6";
    if (p >= 80 && p <= 97 && p != 89) return "R7";
    if (p <= 58 && p != 5 && p != 14 && p != 18 && !(p >= 27 && p <= 28) &&
        p != 34 && !(p >= 42 && p <= 48) && p != 54) return "R5";
    return "R11";
  endfunction

  task automatic mk_exp(input int s, m, h, d, y);
    logic [99:0] b;
    int sbs;
    b = '0;
    b[4:1] = 4'(s % 10);    b[8:6] = 3'(s / 10);
    b[13:10] = 4'(m % 10);  b[17:15] = 3'(m / 10);
    b[23:20] = 4'(h % 10);  b[26:25] = 2'(h / 10);
    b[33:30] = 4'(d % 10);  b[38:35] = 4'((d / 10) % 10); b[41:40] = 2'(d / 100);
    b[53:50] = 4'(y % 10);  b[58:55] = 4'(y / 10);
    b[60] = leap; b[61] = dst; b[65:62] = qual;
    b[66] = ^b[65:1];
    sbs = s + 60 * m + 3600 * h;
    b[88:80] = 9'(sbs); b[97:90] = 8'(sbs >> 9);
    for (int p = 0; p < 100; p++)
      exp_sym[p] = (p == 0 || p % 10 == 9) ? 2 : (b[p] ? 1 : 0);
  endtask

  task automatic cmp_frame(input int idx, input int s, m, h, d, y, input string tag);
    int mism;
    mism = 0;
    mk_exp(s, m, h, d, y);
    for (int p = 0; p < 100; p++) begin
      if (frames[idx][p] != exp_sym[p]) mism++;
      chk(frames[idx][p] == exp_sym[p], $sformatf("%s slot %0d frame %0d", ptag(p), p, idx),
          frames[idx][p], exp_sym[p]);
    end
    chk(mism == 0, $sformatf("%s frame %0d time %0d:%0d:%0d d%0d y%0d", tag, idx, h, m, s, d, y),
        mism, 0);
  endtask

  task automatic run_scn(input int s, m, h, d, y, input int nf);
    do_reset();
    do_load(s, m, h, d, y);
    pulse_pps();
    while (fcnt < nf) @(negedge clk);
    chk(width_err == 0, "R2 pulse widths", width_err, 0);
    for (int i = 1; i < nf; i++)
      chk(frame_rise[i] - frame_rise[i-1] == FRAME_C, "R9 free-run frame period",
          frame_rise[i] - frame_rise[i-1], FRAME_C);
  endtask

  task automatic lat(input int k);
    int n;
    do_reset();
    offset = OFS_W'(k);
    do_load(1, 2, 3, 4, 5);
    pps = 1;
    n = 0;
    while (!code && n < 5000) begin
      @(negedge clk);
      n++;
      if (n == 1) offset = OFS_W'(k + 5);  // R8: late change must not matter
      if (n == 5) pps = 0;
    end
    chk(n == 2 + k * TICK_DIV, $sformatf("R4/R8 start latency offset %0d", k), n, 2 + k * TICK_DIV);
  endtask

  initial begin
    int highs;
    do_reset();
    // R1: idle low after reset, also after a load without reference
    highs = 0;
    for (int i = 0; i < 300; i++) begin
      if (i == 50) begin load = 1; end
      if (i == 51) begin load = 0; end
      @(negedge clk);
      if (code) highs++;
    end
    chk(highs == 0, "R1 output idle before first frame", highs, 0);

    lat(0); lat(1); lat(7); lat(300);

    // midnight in a normal year, year 23 -> 24
    leap = 0; dst = 1; qual = 4'h5;
    run_scn(58, 59, 23, 365, 23, 3);
    cmp_frame(0, 58, 59, 23, 365, 23, "R5");
    cmp_frame(1, 59, 59, 23, 365, 23, "R9");
    cmp_frame(2, 0, 0, 0, 1, 24, "R10");

    // leap second, end of day 366
    leap = 1; dst = 0; qual = 4'hA;
    run_scn(59, 59, 23, 366, 24, 3);
    cmp_frame(0, 59, 59, 23, 366, 24, "R6");
    cmp_frame(1, 60, 59, 23, 366, 24, "R10");
    cmp_frame(2, 0, 0, 0, 1, 25, "R10");

    // day 365 of a leap year
    leap = 0; dst = 1; qual = 4'hF;
    run_scn(59, 59, 23, 365, 24, 2);
    cmp_frame(1, 0, 0, 0, 366, 24, "R10");

    // year 99 wraps
    leap = 0; dst = 0; qual = 4'h3;
    run_scn(59, 59, 23, 365, 99, 2);
    cmp_frame(1, 0, 0, 0, 1, 0, "R10");

    // leap flag off the end of day, hour tens carry
    leap = 1; dst = 1; qual = 4'h0;
    run_scn(59, 59, 9, 99, 9, 2);
    cmp_frame(0, 59, 59, 9, 99, 9, "R7");
    cmp_frame(1, 0, 0, 10, 99, 9, "R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule